// File: doc/BRIEF.md
# Burst Refresh DMA Bus Master

This block keeps a display pipeline supplied with frame-buffer data. It takes the data from shared system memory without holding the system bus for long. When the downstream line buffer raises its need signal, the block requests the bus. Once the grant arrives it performs a short burst of 16-bit reads. The burst is 8 or 16 words, picked by a configuration bit. Each read lasts one clock plus a programmable number of wait states. During that time the block drives the memory address and the active-low chip-select and output-enable strobes.

Each word is handed to the pixel pipeline in the same clock in which the memory returns it, with a one-clock valid strobe. Nothing is stored inside the DMA. The read pointer walks the frame buffer in 2-byte steps from a programmable base byte address and wraps after a programmable number of words.

If the grant is taken away during a burst, the block completes the access in flight and gives up the bus. It keeps its request raised and continues with the next word when the grant returns. At the end of a burst every bus output returns to its idle value on the next clock.

Top module: `rdma_refresh_top`

## Requirements
- R1: `px_valid` is high for exactly one clock per word read. It is never high twice in a row when the wait-state count is nonzero.
- R2: While idle with `lb_need` low, `bus_req` stays low. `bus_req` rises on the clock after `lb_need` is sampled high.
- R3: While the grant has not yet been given, `bus_drive` is 0, `mem_cs_n` and `mem_oe_n` are 1 and `mem_addr` is 0.
- R4: A burst moves 16 words when `cfg_burst16` is 1 and 8 words when it is 0. The value is sampled when the burst starts.
- R5: In the clock where `px_valid` is high, `px_data` equals `mem_rdata` for the address on `mem_addr` in that same clock (flyby, no storage).
- R6: In every clock of an access, wait states included, `bus_drive` is 1 and both `mem_cs_n` and `mem_oe_n` are 0.
- R7: One access lasts `cfg_wait`+1 clocks. Zero wait states gives 1 clock and two gives 3.
- R8: On the clock after the last word of a burst, `bus_req` and `bus_drive` are 0, both strobes are 1 and `mem_addr` is 0.
- R9: The address of word index i is `cfg_base` + 2*i. The index advances by one per word and returns to 0 once it reaches `cfg_frame_words`. It carries over between bursts.
- R10: A grant withdrawn during an access does not shorten that access. On the next clock the bus is released with `bus_req` still high, and the burst resumes at the next address after a new grant.
- R11: A synchronous active-high `rst` makes the block idle with `bus_req` low and returns the word index to 0, so the next burst starts at `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW (24) | Frame-buffer base byte address |
| cfg_frame_words | input | LENW (16) | Frame length in 16-bit words |
| cfg_burst16 | input | 1 | 1: 16-word bursts, 0: 8-word bursts |
| cfg_wait | input | WSW (3) | Wait states added to each access |
| lb_need | input | 1 | Line buffer requests more data |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_drive | output | 1 | High while the block owns and drives the bus |
| mem_addr | output | AW (24) | Read byte address, 0 when not driving |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rdata | input | DW (16) | Memory read data |
| px_data | output | DW (16) | Word forwarded to the pixel pipeline |
| px_valid | output | 1 | One-clock strobe qualifying px_data |

## Verification
The bench holds the grant off after each request to catch a design that drives address or strobes before ownership. It withdraws the grant partway through a multi-clock access. A design that cut the access short would show too few drive clocks for that word. A design that kept the bus would still drive on the following clock. A frame length shorter than one burst forces a wrap mid-burst, which a pointer that failed to wrap or wrapped one word late would get wrong. A reset in the middle of a burst, followed by a new base, shows whether the pointer really returns to the start of the frame.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } rdma_state_e;

    localparam int unsigned WORD_BYTES = 2;

endpackage

// File: rtl/rdma_wait_timer.sv
module rdma_wait_timer #(
    parameter int unsigned WSW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [WSW-1:0] wait_val,
    output logic           done
);

    logic [WSW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = wait_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - WSW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R7: a loaded count reaches the timer in the next clock
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(wait_val)));

    // R7: the wait count steps down by one per clock until zero
    p_countdown_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WSW'(1)));

endmodule

// File: rtl/rdma_addr_gen.sv
module rdma_addr_gen #(
    parameter int unsigned AW   = 24,
    parameter int unsigned LENW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LENW-1:0] cfg_frame_words,
    output logic [AW-1:0]   addr
);
    import rdma_pkg::*;

    localparam int unsigned SHIFT = $clog2(WORD_BYTES);

    logic [LENW-1:0] idx_d, idx_q;
    logic [LENW:0]   idx_inc;
    logic            at_end;

    always_comb begin
        idx_inc = {1'b0, idx_q} + (LENW+1)'(1);
        at_end  = (idx_inc >= {1'b0, cfg_frame_words});
        idx_d   = idx_q;
        if (step) begin
            idx_d = at_end ? '0 : idx_inc[LENW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    assign addr = cfg_base + AW'({idx_q, {SHIFT{1'b0}}});

    // R9: a completed word moves the pointer one word forward
    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (step && !at_end) |=> (idx_q == $past(idx_q) + LENW'(1)));

    // R9: the pointer wraps to the frame start at the frame end
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (step && at_end) |=> (idx_q == '0));

    // R9: no word, no pointer movement
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx_q));

endmodule

// File: rtl/rdma_burst_fsm.sv
module rdma_burst_fsm #(
    parameter int unsigned SHORT_BURST = 8,
    parameter int unsigned LONG_BURST  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic lb_need,
    input  logic burst16,
    input  logic bus_gnt,
    input  logic wait_done,
    output logic bus_req,
    output logic drive,
    output logic start_acc,
    output logic word_done
);
    import rdma_pkg::*;

    localparam int unsigned CNTW = $clog2(LONG_BURST + 1);

    typedef struct packed {
        rdma_state_e     st;
        logic [CNTW-1:0] left;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d         = q;
        start_acc = 1'b0;
        word_done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (lb_need) begin
                    d.st   = ST_REQ;
                    d.left = burst16 ? CNTW'(LONG_BURST) : CNTW'(SHORT_BURST);
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    d.st      = ST_XFER;
                    start_acc = 1'b1;
                end
            end
            ST_XFER: begin
                if (wait_done) begin
                    word_done = 1'b1;
                    d.left    = q.left - CNTW'(1);
                    if (q.left == CNTW'(1)) begin
                        d.st = ST_IDLE;
                    end else if (!bus_gnt) begin
                        d.st = ST_REQ;
                    end else begin
                        start_acc = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_IDLE, left: '0};
        else     q <= d;
    end

    assign bus_req = (q.st != ST_IDLE);
    assign drive   = (q.st == ST_XFER);

    // R2: no request appears without the line buffer asking
    p_need_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && !lb_need) |=> !bus_req);

    // R3: ownership of the bus begins only after a grant
    p_grant_first_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(bus_gnt));

    // R4: burst size taken from the configuration bit at burst start
    p_burst_size_r4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && lb_need) |=>
        (q.left == ($past(burst16) ? CNTW'(LONG_BURST) : CNTW'(SHORT_BURST))));

    // R8: last word releases request and bus together
    p_last_release_r8: assert property (@(posedge clk) disable iff (rst)
        (drive && wait_done && q.left == CNTW'(1)) |=> (!bus_req && !drive));

    // R10: withdrawn grant releases the bus but keeps the request
    p_withdraw_r10: assert property (@(posedge clk) disable iff (rst)
        (drive && wait_done && q.left > CNTW'(1) && !bus_gnt) |=> (bus_req && !drive));

    // R10: an access in progress is never abandoned
    p_finish_access_r10: assert property (@(posedge clk) disable iff (rst)
        (drive && !wait_done) |=> drive);

endmodule

// File: rtl/rdma_refresh_top.sv
module rdma_refresh_top #(
    parameter int unsigned AW          = 24,
    parameter int unsigned LENW        = 16,
    parameter int unsigned WSW         = 3,
    parameter int unsigned DW          = 16,
    parameter int unsigned SHORT_BURST = 8,
    parameter int unsigned LONG_BURST  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LENW-1:0] cfg_frame_words,
    input  logic            cfg_burst16,
    input  logic [WSW-1:0]  cfg_wait,
    input  logic            lb_need,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_drive,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_oe_n,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   px_data,
    output logic            px_valid
);

    logic          start_acc;
    logic          word_done;
    logic          wait_done;
    logic          drive;
    logic [AW-1:0] ptr_addr;

    rdma_burst_fsm #(
        .SHORT_BURST (SHORT_BURST),
        .LONG_BURST  (LONG_BURST)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .lb_need   (lb_need),
        .burst16   (cfg_burst16),
        .bus_gnt   (bus_gnt),
        .wait_done (wait_done),
        .bus_req   (bus_req),
        .drive     (drive),
        .start_acc (start_acc),
        .word_done (word_done)
    );

    rdma_wait_timer #(
        .WSW (WSW)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (start_acc),
        .wait_val (cfg_wait),
        .done     (wait_done)
    );

    rdma_addr_gen #(
        .AW   (AW),
        .LENW (LENW)
    ) addr_i (
        .clk             (clk),
        .rst             (rst),
        .step            (word_done),
        .cfg_base        (cfg_base),
        .cfg_frame_words (cfg_frame_words),
        .addr            (ptr_addr)
    );

    assign bus_drive = drive;
    assign mem_addr  = drive ? ptr_addr : '0;
    assign mem_cs_n  = ~drive;
    assign mem_oe_n  = ~drive;
    assign px_data   = mem_rdata;
    assign px_valid  = word_done;

    // R5: a word is only forwarded while the memory is being driven
    p_flyby_r5: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> (bus_drive && !mem_oe_n));

    // R11: the cycle after reset the block is idle
    p_reset_idle_r11: assert property (@(posedge clk)
        $past(rst) |-> (!bus_req && !bus_drive));

endmodule

// File: tb/rdma_refresh_top_tb_top.sv
module rdma_refresh_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 24;
    localparam int LENW = 16;
    localparam int WSW  = 3;
    localparam int DW   = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   cfg_base = 24'h010000;
    logic [LENW-1:0] cfg_frame_words = 16'd100;
    logic            cfg_burst16 = 1'b0;
    logic [WSW-1:0]  cfg_wait = '0;
    logic            lb_need = 1'b0;
    logic            bus_req;
    logic            bus_gnt = 1'b0;
    logic            bus_drive;
    logic [AW-1:0]   mem_addr;
    logic            mem_cs_n;
    logic            mem_oe_n;
    logic [DW-1:0]   mem_rdata;
    logic [DW-1:0]   px_data;
    logic            px_valid;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    int idx_m  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: data is a function of the word address
    assign mem_rdata = mem_addr[16:1] ^ 16'h5A3C;

    rdma_refresh_top dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_base        (cfg_base),
        .cfg_frame_words (cfg_frame_words),
        .cfg_burst16     (cfg_burst16),
        .cfg_wait        (cfg_wait),
        .lb_need         (lb_need),
        .bus_req         (bus_req),
        .bus_gnt         (bus_gnt),
        .bus_drive       (bus_drive),
        .mem_addr        (mem_addr),
        .mem_cs_n        (mem_cs_n),
        .mem_oe_n        (mem_oe_n),
        .mem_rdata       (mem_rdata),
        .px_data         (px_data),
        .px_valid        (px_valid)
    );

    typedef struct packed {
        logic        b16;
        logic [2:0]  ws;
        logic [15:0] len;
        logic [23:0] base;
        logic [4:0]  drop;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 3'd0, 16'd100, 24'h010000, 5'd0},
        '{1'b1, 3'd0, 16'd100, 24'h010000, 5'd0},
        '{1'b0, 3'd2, 16'd100, 24'h010000, 5'd0},
        '{1'b1, 3'd3, 16'd100, 24'h010000, 5'd5},
        '{1'b0, 3'd1, 16'd5,   24'h020400, 5'd0},
        '{1'b1, 3'd0, 16'd7,   24'h020400, 5'd3},
        '{1'b0, 3'd7, 16'd100, 24'h003000, 5'd2}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr();
        return cfg_base + AW'(2 * idx_m);
    endfunction

    task automatic run_burst(input logic b16, input logic [2:0] ws, input logic [15:0] len,
                             input logic [23:0] base, input int drop);
        int  exp_words = b16 ? 16 : 8;
        int  words = 0;
        int  cyc = 0;
        int  guard = 0;
        bit  dropped = 0;
        bit  pend = 0;
        bit  prev_valid = 0;
        logic [AW-1:0] ea;
        cfg_burst16     = b16;
        cfg_wait        = ws;
        cfg_frame_words = len;
        cfg_base        = base;
        lb_need         = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b1, "R2 request after need", bus_req, 1);
        lb_need = 1'b0;
        chk(!bus_drive && mem_cs_n && mem_oe_n && mem_addr == '0, "R3 idle before grant",
            {bus_drive, mem_cs_n, mem_oe_n}, 3'b011);
        @(negedge clk);
        chk(!bus_drive && mem_cs_n && mem_oe_n && mem_addr == '0, "R3 still idle before grant",
            {bus_drive, mem_cs_n, mem_oe_n}, 3'b011);
        bus_gnt = 1'b1;
        while (words < exp_words && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (bus_drive) begin
                cyc++;
                chk(!mem_cs_n && !mem_oe_n, "R6 strobes during access", {mem_cs_n, mem_oe_n}, 0);
            end
            if (drop != 0 && !dropped && words == drop && bus_drive && cyc == 1) begin
                bus_gnt = 1'b0;
                dropped = 1'b1;
                pend    = 1'b1;
            end
            if (px_valid) begin
                ea = exp_addr();
                chk(!(prev_valid && ws != 0), "R1 single-clock valid", prev_valid, 0);
                chk(cyc == int'(ws) + 1, "R7 access length", cyc, int'(ws) + 1);
                chk(mem_addr == ea, "R9 address", mem_addr, ea);
                chk(px_data == (ea[16:1] ^ 16'h5A3C), "R5 flyby data", px_data, ea[16:1] ^ 16'h5A3C);
                words++;
                cyc   = 0;
                idx_m = (idx_m + 1 >= int'(len)) ? 0 : idx_m + 1;
                if (pend) begin
                    pend = 1'b0;
                    @(negedge clk);
                    chk(!bus_drive && bus_req, "R10 released with request held",
                        {bus_drive, bus_req}, 2'b01);
                    @(negedge clk);
                    chk(!bus_drive && bus_req && mem_cs_n, "R10 waits for regrant",
                        {bus_drive, bus_req}, 2'b01);
                    bus_gnt = 1'b1;
                    prev_valid = 1'b0;
                end else begin
                    prev_valid = 1'b1;
                end
            end else begin
                prev_valid = 1'b0;
            end
        end
        chk(words == exp_words, "R4 words in burst", words, exp_words);
        @(negedge clk);
        chk(!bus_req && !bus_drive && mem_cs_n && mem_oe_n && mem_addr == '0 && !px_valid,
            "R8 bus idle after burst", {bus_req, bus_drive, mem_cs_n, mem_oe_n}, 4'b0011);
        bus_gnt = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_drive && mem_cs_n && mem_oe_n, "R11 state in reset",
            {bus_req, bus_drive}, 0);
        rst = 1'b0;

        // R2: no request while the line buffer is satisfied
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!bus_req, "R2 no request without need", bus_req, 0);
        end

        foreach (VECS[k]) begin
            run_burst(VECS[k].b16, VECS[k].ws, VECS[k].len, VECS[k].base, int'(VECS[k].drop));
            repeat (2) @(negedge clk);
        end

        // R11: reset in the middle of a burst
        cfg_burst16 = 1'b1;
        cfg_wait    = 3'd1;
        lb_need     = 1'b1;
        @(negedge clk);
        lb_need = 1'b0;
        bus_gnt = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!bus_req && !bus_drive && !px_valid, "R11 reset mid-burst", {bus_req, bus_drive}, 0);
        rst     = 1'b0;
        bus_gnt = 1'b0;
        idx_m   = 0;
        @(negedge clk);
        chk(!bus_req, "R11 idle after reset", bus_req, 0);
        // next burst must begin at the new base (R11 via address checks)
        run_burst(1'b0, 3'd0, 16'd100, 24'h044000, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule